// File: doc/BRIEF.md
# Byte-Wide Configuration Data Loader

This block takes in configuration data eight bits at a time, one byte on each rising edge of a configuration clock that an external source drives. A three-bit mode input selects byte-wide loading. While the mode input holds any other code, the block stays idle. Accepted bytes are packed into a frame register. When a frame completes, the whole frame word goes to a downstream sink together with a one-cycle valid strobe.

The block computes no CRC and keeps no length count. Corruption is caught only through fixed fields. Every frame must open with the start marker 0xFE and close with the end marker 0xFF. A wrong marker raises a sticky error and loading stops. Loading ends when the start-marker position holds two consecutive 0x00 bytes. That raises done, and every byte after it is ignored.

The first clock edge that sees the loading mode only arms the block. The first data byte is taken on the edge after that. Leaving the mode, or a synchronous reset, returns the block to idle and clears both flags.

Top module: `bytewide_cfg_loader`

## Requirements
- R1: Loading is active only while `mode_pins` reads 3'b010 (bit 2 first). After any edge at which it reads another code, `frame_valid`, `cfg_error` and `cfg_done` are low, and no byte on `cfg_byte` takes effect.
- R2: The first edge that sees mode 3'b010 after idle only arms the block and ignores `cfg_byte`. The first frame byte is taken on the next edge, and one byte is taken on every edge after that.
- R3: A frame of FRAME_BYTES bytes (default 6) is packed first byte most significant: the first byte in `frame_data[8*FRAME_BYTES-1 -: 8]` and the last in `frame_data[7:0]`. `frame_data` changes only together with `frame_valid` or by reset.
- R4: `frame_valid` is high for exactly one cycle, directly after the edge that takes a frame's last byte. The frame's first byte must be 0xFE and its last byte 0xFF. Middle bytes may hold any value.
- R5: A first-position byte that is neither 0xFE nor 0x00 sets `cfg_error` after that edge.
- R6: A last-position byte other than 0xFF sets `cfg_error` and produces no `frame_valid`.
- R7: `cfg_error` is sticky until reset or until the mode is left. While it is set there is no `frame_valid` and `cfg_done` stays low.
- R8: 0x00 in the first position followed by 0x00 sets `cfg_done`. `cfg_done` is sticky. After it, further bytes produce no `frame_valid` and leave `frame_data` unchanged.
- R9: 0x00 in the first position followed by any nonzero byte sets `cfg_error`.
- R10: A synchronous active-high `cfg_rst` clears all outputs, `frame_data` included, to zero after the edge. Loading then restarts with an arming edge.
- R11: `cfg_error` and `cfg_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Externally driven configuration clock |
| cfg_rst | input | 1 | Synchronous reset, active high |
| mode_pins | input | 3 | Mode select; 3'b010 enables byte-wide loading |
| cfg_byte | input | 8 | Configuration data byte |
| frame_data | output | 8*FRAME_BYTES | Last completed frame, first byte most significant |
| frame_valid | output | 1 | One-cycle strobe for a new frame |
| cfg_error | output | 1 | Sticky fixed-field error |
| cfg_done | output | 1 | Sticky end-of-configuration flag |

## Verification
Every output is a register, so each result belongs to the same edge that takes its byte. `frame_valid` and `frame_data` follow the edge that takes the end marker. The flags follow the edge that takes the offending or terminating byte. A mode change shows its effect after one edge. The bench drives each byte at the falling edge and samples two nanoseconds after the next rising edge. The scoreboard monitor pops an expected frame at exactly that point, and any strobe with nothing queued counts as a failure.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOAD  = 3'd1,
    S_EOC   = 3'd2,
    S_DONE  = 3'd3,
    S_FAULT = 3'd4
  } load_state_t;

  localparam logic [2:0] MODE_BYTEWIDE = 3'b010;
  localparam logic [7:0] START_MARK    = 8'hFE;
  localparam logic [7:0] END_MARK      = 8'hFF;
  localparam logic [7:0] EOC_MARK      = 8'h00;
endpackage

// File: rtl/cfgl_mode_decode.sv
module cfgl_mode_decode #(
  parameter int         MODE_W    = 3,
  parameter logic [2:0] MODE_CODE = 3'b010
) (
  input  logic [MODE_W-1:0] mode_pins,
  output logic              active
);
  always_comb active = (mode_pins == MODE_CODE[MODE_W-1:0]);
endmodule

// File: rtl/cfgl_field_check.sv
module cfgl_field_check #(
  parameter int         FRAME_BYTES = 6,
  parameter logic [7:0] START_CODE  = 8'hFE,
  parameter logic [7:0] END_CODE    = 8'hFF,
  parameter logic [7:0] EOC_CODE    = 8'h00,
  localparam int        PW          = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 1
) (
  input  logic [7:0]    byte_in,
  input  logic [PW-1:0] pos,
  output logic          at_first,
  output logic          at_last,
  output logic          is_start,
  output logic          is_end,
  output logic          is_eoc
);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BYTES - 1);

  always_comb begin
    at_first = (pos == '0);
    at_last  = (pos == LAST_POS);
    is_start = (byte_in == START_CODE);
    is_end   = (byte_in == END_CODE);
    is_eoc   = (byte_in == EOC_CODE);
  end
endmodule

// File: rtl/cfgl_byte_shifter.sv
module cfgl_byte_shifter #(
  parameter int  FRAME_BYTES = 6,
  localparam int PW          = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 1,
  localparam int HOLD        = FRAME_BYTES - 1,
  localparam int FW          = 8 * FRAME_BYTES
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          shift_en,
  input  logic [7:0]    byte_in,
  output logic [PW-1:0] pos,
  output logic [FW-1:0] next_frame
);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BYTES - 1);

  logic [7:0] lane [HOLD];

  // lane 0 holds the newest byte; lane HOLD-1 holds the frame's first byte
  always_ff @(posedge clk) begin
    if (shift_en) lane[0] <= byte_in;
  end

  for (genvar i = 1; i < HOLD; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (shift_en) lane[i] <= lane[i-1];
    end
  end

  for (genvar i = 0; i < HOLD; i++) begin : g_pack
    assign next_frame[8*(i+1) +: 8] = lane[i];
  end
  assign next_frame[7:0] = byte_in;

  always_ff @(posedge clk) begin
    if (clr)                            pos <= '0;
    else if (shift_en && pos == LAST_POS) pos <= '0;
    else if (shift_en)                  pos <= pos + 1'b1;
  end
endmodule

// File: rtl/bytewide_cfg_loader.sv
module bytewide_cfg_loader
  import cfgl_pkg::*;
#(
  parameter int         FRAME_BYTES = 6,
  parameter logic [2:0] MODE_CODE   = MODE_BYTEWIDE,
  parameter logic [7:0] START_CODE  = START_MARK,
  parameter logic [7:0] END_CODE    = END_MARK,
  parameter logic [7:0] EOC_CODE    = EOC_MARK,
  localparam int        FW          = 8 * FRAME_BYTES,
  localparam int        PW          = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 1
) (
  input  logic          cfg_clk,
  input  logic          cfg_rst,
  input  logic [2:0]    mode_pins,
  input  logic [7:0]    cfg_byte,
  output logic [FW-1:0] frame_data,
  output logic          frame_valid,
  output logic          cfg_error,
  output logic          cfg_done
);
  if (FRAME_BYTES < 2) begin : g_bad_size
    initial $display("bytewide_cfg_loader: FRAME_BYTES must be at least 2");
  end

  load_state_t   state;
  logic          active;
  logic          at_first, at_last, is_start, is_end, is_eoc;
  logic          shift_en, clr;
  logic [PW-1:0] pos;
  logic [FW-1:0] next_frame;

  cfgl_mode_decode #(.MODE_W(3), .MODE_CODE(MODE_CODE)) u_mode (
    .mode_pins (mode_pins),
    .active    (active)
  );

  cfgl_field_check #(
    .FRAME_BYTES (FRAME_BYTES),
    .START_CODE  (START_CODE),
    .END_CODE    (END_CODE),
    .EOC_CODE    (EOC_CODE)
  ) u_field (
    .byte_in  (cfg_byte),
    .pos      (pos),
    .at_first (at_first),
    .at_last  (at_last),
    .is_start (is_start),
    .is_end   (is_end),
    .is_eoc   (is_eoc)
  );

  cfgl_byte_shifter #(.FRAME_BYTES(FRAME_BYTES)) u_shift (
    .clk        (cfg_clk),
    .clr        (clr),
    .shift_en   (shift_en),
    .byte_in    (cfg_byte),
    .pos        (pos),
    .next_frame (next_frame)
  );

  // byte acceptance: markers gate shifting so a bad frame never reaches the sink
  always_comb begin
    clr      = cfg_rst || !active || (state == S_IDLE);
    shift_en = 1'b0;
    if (!clr && state == S_LOAD) begin
      if (at_first)     shift_en = is_start;
      else if (at_last) shift_en = is_end;
      else              shift_en = 1'b1;
    end
  end

  always_ff @(posedge cfg_clk) begin
    if (cfg_rst || !active) begin
      state       <= S_IDLE;
      frame_valid <= 1'b0;
      cfg_error   <= 1'b0;
      cfg_done    <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      unique case (state)
        S_IDLE: state <= S_LOAD;
        S_LOAD: begin
          if (at_first) begin
            if (is_eoc) state <= S_EOC;
            else if (!is_start) begin
              state     <= S_FAULT;
              cfg_error <= 1'b1;
            end
          end else if (at_last) begin
            if (is_end) frame_valid <= 1'b1;
            else begin
              state     <= S_FAULT;
              cfg_error <= 1'b1;
            end
          end
        end
        S_EOC: begin
          if (is_eoc) begin
            state    <= S_DONE;
            cfg_done <= 1'b1;
          end else begin
            state     <= S_FAULT;
            cfg_error <= 1'b1;
          end
        end
        S_DONE:  state <= S_DONE;
        S_FAULT: state <= S_FAULT;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge cfg_clk) begin
    if (cfg_rst) frame_data <= '0;
    else if (active && state == S_LOAD && at_last && is_end) frame_data <= next_frame;
  end
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
  parameter int         FW        = 48,
  parameter logic [2:0] MODE_CODE = 3'b010,
  parameter logic [7:0] EOC_CODE  = 8'h00
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mode_pins,
  input logic [7:0]    cfg_byte,
  input logic [FW-1:0] frame_data,
  input logic          frame_valid,
  input logic          cfg_error,
  input logic          cfg_done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_pins != MODE_CODE) |=> (!frame_valid && !cfg_error && !cfg_done));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_data) |-> (frame_valid || $past(rst)));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_error && mode_pins == MODE_CODE) |=> cfg_error);

  p_err_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_error |-> !frame_valid);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && mode_pins == MODE_CODE) |=> (cfg_done && !frame_valid));

  p_done_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> ($past(cfg_byte) == EOC_CODE));

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(cfg_error && cfg_done));
endmodule

bind bytewide_cfg_loader cfgl_checker #(
  .FW        (8 * FRAME_BYTES),
  .MODE_CODE (MODE_CODE),
  .EOC_CODE  (EOC_CODE)
) u_chk (
  .clk         (cfg_clk),
  .rst         (cfg_rst),
  .mode_pins   (mode_pins),
  .cfg_byte    (cfg_byte),
  .frame_data  (frame_data),
  .frame_valid (frame_valid),
  .cfg_error   (cfg_error),
  .cfg_done    (cfg_done)
);

// File: tb/sim_bytewide_cfg_loader.sv
`timescale 1ns/1ps
module sim_bytewide_cfg_loader;
  localparam int FB = 6;
  localparam int FW = 8 * FB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode = 3'b000;
  logic [7:0]    din = 8'h00;
  logic [FW-1:0] frame_data;
  logic          frame_valid, cfg_error, cfg_done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [FW-1:0] expq[$];
  logic [FW-1:0] last_frame = '0;

  always #5 clk = ~clk;

  bytewide_cfg_loader #(.FRAME_BYTES(FB)) u0 (
    .cfg_clk     (clk),
    .cfg_rst     (rst),
    .mode_pins   (mode),
    .cfg_byte    (din),
    .frame_data  (frame_data),
    .frame_valid (frame_valid),
    .cfg_error   (cfg_error),
    .cfg_done    (cfg_done)
  );

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the oldest queued frame
  always @(posedge clk) begin
    #2;
    if (!rst && frame_valid === 1'b1) begin
      if (expq.size() == 0) begin
        tests++; fails++;
        $display("FAIL R4 actual=unexpected strobe %0h expected=no strobe", frame_data);
      end else begin
        logic [FW-1:0] e;
        e = expq.pop_front();
        check("R3/R4 frame", frame_data, e);
        last_frame = e;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); din = b; @(posedge clk); #2;
  endtask

  task automatic set_mode(input logic [2:0] m, input logic [7:0] b);
    @(negedge clk); mode = m; din = b; @(posedge clk); #2;
  endtask

  task automatic send_frame(input logic [31:0] pay, input logic [7:0] first,
                            input logic [7:0] last, input bit expect_ok);
    logic [FW-1:0] f;
    f = {first, pay, last};
    if (expect_ok) expq.push_back(f);
    for (int i = FB - 1; i >= 0; i--) send_byte(f[8*i +: 8]);
  endtask

  task automatic flags(input string req, input logic v, input logic e, input logic d);
    check(req, {frame_valid, cfg_error, cfg_done}, {v, e, d});
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset with loading mode already selected
    mode = 3'b010;
    repeat (2) @(posedge clk);
    #2;
    flags("R10 reset flags", 1'b0, 1'b0, 1'b0);
    check("R10 reset data", frame_data, '0);
    @(negedge clk); rst = 1'b0; din = 8'h5A;
    // R2: this edge only arms, 0x5A would otherwise be a bad start marker
    @(posedge clk); #2;
    flags("R2 arm edge ignored", 1'b0, 1'b0, 1'b0);
    send_frame(32'h01234567, 8'hFE, 8'hFF, 1'b1);
    flags("R4 after frame", 1'b1, 1'b0, 1'b0);
    send_frame(32'hFEFF00A5, 8'hFE, 8'hFF, 1'b1);
    send_frame(32'h00000000, 8'hFE, 8'hFF, 1'b1);
    flags("R4 back-to-back", 1'b1, 1'b0, 1'b0);
    check("R3 first byte msb", frame_data[FW-1 -: 8], 8'hFE);
    check("R3 last byte lsb", frame_data[7:0], 8'hFF);

    // R8: end-of-configuration pattern
    send_byte(8'h00);
    flags("R8 one zero", 1'b0, 1'b0, 1'b0);
    send_byte(8'h00);
    flags("R8 done set", 1'b0, 1'b0, 1'b1);
    send_frame(32'hDEADBEEF, 8'hFE, 8'hFF, 1'b0);
    flags("R8 done sticky", 1'b0, 1'b0, 1'b1);
    check("R8 data unchanged", frame_data, last_frame);

    // R1: leaving mode clears flags; frames in other modes are ignored
    set_mode(3'b011, 8'hFE);
    flags("R1 mode exit", 1'b0, 1'b0, 1'b0);
    set_mode(3'b110, 8'hFE);
    send_frame(32'h11223344, 8'hFE, 8'hFF, 1'b0);
    flags("R1 other mode", 1'b0, 1'b0, 1'b0);
    check("R1 data unchanged", frame_data, last_frame);

    // R5 and R7: bad start marker
    set_mode(3'b010, 8'h77);
    send_byte(8'h7E);
    flags("R5 bad start", 1'b0, 1'b1, 1'b0);
    send_frame(32'h55667788, 8'hFE, 8'hFF, 1'b0);
    send_byte(8'h00); send_byte(8'h00);
    flags("R7 error sticky", 1'b0, 1'b1, 1'b0);

    // R6: bad end marker
    set_mode(3'b000, 8'h00);
    set_mode(3'b010, 8'h00);
    send_frame(32'hCAFEF00D, 8'hFE, 8'hFE, 1'b0);
    flags("R6 bad end", 1'b0, 1'b1, 1'b0);
    check("R6 data unchanged", frame_data, last_frame);

    // R9: zero then nonzero in start position
    set_mode(3'b111, 8'h00);
    set_mode(3'b010, 8'h00);
    send_frame(32'h0BADF00D, 8'hFE, 8'hFF, 1'b1);
    send_byte(8'h00);
    send_byte(8'h01);
    flags("R9 broken terminator", 1'b0, 1'b1, 1'b0);

    // R10: reset mid-load clears error and data, then loading restarts after arming
    @(negedge clk); rst = 1'b1; @(posedge clk); #2;
    flags("R10 reset clears error", 1'b0, 1'b0, 1'b0);
    check("R10 reset clears data", frame_data, '0);
    last_frame = '0;
    @(negedge clk); rst = 1'b0; din = 8'h00;
    @(posedge clk); #2;
    send_frame(32'h89ABCDEF, 8'hFE, 8'hFF, 1'b1);
    flags("R10 restart frame", 1'b1, 1'b0, 1'b0);
    send_byte(8'h00); send_byte(8'h00);
    flags("R11 done only", 1'b0, 1'b0, 1'b1);

    repeat (3) @(posedge clk);
    #2;
    check("R4 queue drained", FW'(expq.size()), '0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule